// File: doc/BRIEF.md
# Serial Transmitter with Queued Break and Idle Characters

This block turns parallel characters into an asynchronous serial bit stream on one output line. Software places a character in a one-entry holding buffer. When the shift stage is free the character moves across, and the line then carries a start bit, eight or nine data bits (least significant first) and a stop bit. Every bit lasts a fixed number of baud-tick pulses. The baud-tick pulse comes from a divider outside the block.

Besides data, the transmitter can send two whole-character special symbols. A line-break symbol holds the line low for a full character time, the stop position included. An idle symbol holds the line high for a full character time, which gives listeners a gap between messages. Both wait behind the character already in the shift stage. Dropping the enable input does not give up the line at once: the block keeps the pin until the character in flight and any queued break or idle symbol have finished.

Top module: `utx_core`

## Requirements
- R1: After reset the line is 1, buf_empty is 1, tx_done is 1 and line_own is 0 while ctl_enable is 0.
- R2: In 8-bit mode (ctl_nine=0) a data character is sent as one start bit of 0, data bits 0 to 7 in ascending order, and one stop bit of 1. Each bit lasts OVS baud ticks (default 16).
- R3: With ctl_nine=1 at load time, data bits 0 to 8 are sent in ascending order between the start and stop bits, so the frame is 11 bits long.
- R4: A write (wr_valid=1) clears buf_empty and tx_done on the next cycle. The held character moves to the shift stage only on a baud-tick cycle while ctl_enable is 1 and the shift stage is free or finishing, and buf_empty is 1 from the next cycle. While ctl_enable is 0 the held character stays held.
- R5: When a character finishes and nothing is loaded on that cycle, tx_done becomes 1 and the line stays 1.
- R6: A 0-to-1 change on ctl_break queues one break symbol. The line is then 0 for (bits + 2) x OVS ticks: 160 ticks in 8-bit mode and 176 ticks in 9-bit mode.
- R7: If ctl_break is still 1 on the cycle a queued break enters the shift stage, a further break is queued, so the low periods run back to back.
- R8: A 0-to-1 change on ctl_enable queues an idle symbol: the line is 1 for one full character time before the next queued character may start.
- R9: When the shift stage frees, a pending data character goes first, then a queued break, then a queued idle. Each queued request clears once it is loaded.
- R10: line_own is 1 while ctl_enable is 1, while a character is being shifted, or while a break or idle is queued. When line_own is 0 the line is 1.
- R11: Bit timing advances only on baud-tick cycles. With no ticks the line and the holding buffer do not change, and ticks on every second cycle double every duration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_enable | input | 1 | Transmitter enable level |
| ctl_break | input | 1 | Send-break control level |
| ctl_nine | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| wr_valid | input | 1 | One-cycle write strobe for the holding buffer |
| wr_data | input | BASE_BITS+1 | Character to hold (upper bit used in 9-bit mode only) |
| baud_tick | input | 1 | One pulse per baud sub-interval |
| buf_empty | output | 1 | Holding buffer is free |
| tx_done | output | 1 | Transmission complete, shift stage idle |
| tx_line | output | 1 | Serial output line |
| line_own | output | 1 | Transmitter claims the output pin |

## Verification
The bench measures low periods to the cycle. A break of the wrong length, a break that omits the stop position, or a held send-break that fails to repeat shows up as a run other than 160, 176 or 320 cycles. The idle preamble is timed from the enable toggle to the next start bit, so a design that drops the idle or lets it jump ahead of data produces a start bit near the toggle instead of about 162 cycles later. Ownership is probed mid-frame after enable falls and during a break sent with enable low; a design that releases the pin early reads 0 there. Finally, the bench stops the ticks and then halves their rate, to catch a buffer that empties without a tick and a bit counter that counts clocks instead of ticks.

// File: rtl/utx_pkg.sv
package utx_pkg;

   typedef enum logic [1:0] {
      KIND_DATA  = 2'd0,
      KIND_BREAK = 2'd1,
      KIND_IDLE  = 2'd2,
      KIND_NONE  = 2'd3
   } utx_kind_e;

endpackage

// File: rtl/utx_bit_timer.sv
module utx_bit_timer #(
   parameter int OVS = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic restart,
   input  logic tick,
   output logic bit_end
);
   localparam int CW = (OVS > 2) ? $clog2(OVS) : 1;
   localparam bit POW2 = ((OVS & (OVS - 1)) == 0);

   logic [CW-1:0] tcnt;

   generate
      if (POW2) begin : g_wrap
         // power-of-two length: counter wraps by itself
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)               tcnt <= '0;
            else if (restart || !run) tcnt <= '0;
            else if (tick)            tcnt <= tcnt + 1'b1;
         end
         assign bit_end = run && tick && (&tcnt);
      end else begin : g_cmp
         localparam logic [CW-1:0] LAST = CW'(OVS - 1);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)               tcnt <= '0;
            else if (restart || !run) tcnt <= '0;
            else if (tick)            tcnt <= (tcnt == LAST) ? '0 : tcnt + 1'b1;
         end
         assign bit_end = run && tick && (tcnt == LAST);
      end
   endgenerate

endmodule

// File: rtl/utx_req_queue.sv
module utx_req_queue
   import utx_pkg::*;
#(
   parameter int DW = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ctl_enable,
   input  logic          ctl_break,
   input  logic          wr_valid,
   input  logic [DW-1:0] wr_data,
   input  logic          load_slot,
   output logic          load_go,
   output utx_kind_e     load_kind,
   output logic [DW-1:0] hold_data,
   output logic          buf_empty,
   output logic          pend_brk,
   output logic          pend_idle
);
   logic en_q, brk_prev, hold_full;
   logic en_rise, brk_rise, data_rdy;

   assign en_rise  = ctl_enable && !en_q;
   assign brk_rise = ctl_break && !brk_prev;
   assign data_rdy = hold_full && ctl_enable;

   // fixed order: data, then break, then idle
   always_comb begin
      if (data_rdy)       load_kind = KIND_DATA;
      else if (pend_brk)  load_kind = KIND_BREAK;
      else if (pend_idle) load_kind = KIND_IDLE;
      else                load_kind = KIND_NONE;
   end

   assign load_go   = load_slot && (load_kind != KIND_NONE);
   assign buf_empty = !hold_full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q     <= 1'b0;
         brk_prev <= 1'b0;
      end else begin
         en_q     <= ctl_enable;
         brk_prev <= ctl_break;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_full <= 1'b0;
         hold_data <= '0;
      end else if (wr_valid) begin
         hold_full <= 1'b1;
         hold_data <= wr_data;
      end else if (load_go && load_kind == KIND_DATA) begin
         hold_full <= 1'b0;
      end
   end

   // break re-arms itself if the control level is still high at load
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    pend_brk <= 1'b0;
      else if (load_go && load_kind == KIND_BREAK)   pend_brk <= ctl_break;
      else if (brk_rise)                             pend_brk <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    pend_idle <= 1'b0;
      else if (load_go && load_kind == KIND_IDLE)    pend_idle <= en_rise;
      else if (en_rise)                              pend_idle <= 1'b1;
   end

endmodule

// File: rtl/utx_shifter.sv
module utx_shifter
   import utx_pkg::*;
#(
   parameter int BASE_BITS = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load_go,
   input  utx_kind_e          load_kind,
   input  logic               nine,
   input  logic [BASE_BITS:0] data,
   input  logic               bit_end,
   output logic               busy,
   output logic               char_end,
   output logic               line
);
   localparam int FW = BASE_BITS + 3;
   localparam int LW = $clog2(FW + 1);

   logic [FW-1:0] frm_data, frame, sr;
   logic [LW-1:0] bits_left, frame_len;

   // data frame: start, data LSB first, optional ninth bit, stop
   generate
      for (genvar gi = 0; gi < FW; gi++) begin : g_frm
         if (gi == 0) begin : g_start
            assign frm_data[gi] = 1'b0;
         end else if (gi <= BASE_BITS) begin : g_dat
            assign frm_data[gi] = data[gi-1];
         end else if (gi == BASE_BITS + 1) begin : g_opt
            assign frm_data[gi] = nine ? data[BASE_BITS] : 1'b1;
         end else begin : g_stop
            assign frm_data[gi] = 1'b1;
         end
      end
   endgenerate

   always_comb begin
      case (load_kind)
         KIND_DATA:  frame = frm_data;
         KIND_BREAK: frame = '0;
         default:    frame = '1;
      endcase
   end

   assign frame_len = nine ? LW'(FW) : LW'(FW - 1);
   assign char_end  = bit_end && (bits_left == LW'(1));
   assign line      = busy ? sr[0] : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr        <= '1;
         bits_left <= '0;
         busy      <= 1'b0;
      end else if (load_go) begin
         sr        <= frame;
         bits_left <= frame_len;
         busy      <= 1'b1;
      end else if (bit_end) begin
         sr        <= {1'b1, sr[FW-1:1]};
         bits_left <= bits_left - 1'b1;
         if (bits_left == LW'(1)) busy <= 1'b0;
      end
   end

endmodule

// File: rtl/utx_core.sv
module utx_core
   import utx_pkg::*;
#(
   parameter int OVS       = 16,
   parameter int BASE_BITS = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ctl_enable,
   input  logic               ctl_break,
   input  logic               ctl_nine,
   input  logic               wr_valid,
   input  logic [BASE_BITS:0] wr_data,
   input  logic               baud_tick,
   output logic               buf_empty,
   output logic               tx_done,
   output logic               tx_line,
   output logic               line_own
);
   localparam int DW = BASE_BITS + 1;

   generate
      if (OVS < 2) begin : g_bad_ovs
         $error("utx_core: OVS must be at least 2");
      end
      if (BASE_BITS < 5 || BASE_BITS > 16) begin : g_bad_bits
         $error("utx_core: BASE_BITS must lie in 5..16");
      end
   endgenerate

   logic          busy, char_end, bit_end, load_slot, load_go;
   logic          pend_brk, pend_idle;
   utx_kind_e     load_kind;
   logic [DW-1:0] hold_data;

   assign load_slot = baud_tick && (!busy || char_end);

   utx_req_queue #(.DW(DW)) u_queue (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctl_enable (ctl_enable),
      .ctl_break  (ctl_break),
      .wr_valid   (wr_valid),
      .wr_data    (wr_data),
      .load_slot  (load_slot),
      .load_go    (load_go),
      .load_kind  (load_kind),
      .hold_data  (hold_data),
      .buf_empty  (buf_empty),
      .pend_brk   (pend_brk),
      .pend_idle  (pend_idle)
   );

   utx_bit_timer #(.OVS(OVS)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (busy),
      .restart (load_go),
      .tick    (baud_tick),
      .bit_end (bit_end)
   );

   utx_shifter #(.BASE_BITS(BASE_BITS)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_go   (load_go),
      .load_kind (load_kind),
      .nine      (ctl_nine),
      .data      (hold_data),
      .bit_end   (bit_end),
      .busy      (busy),
      .char_end  (char_end),
      .line      (tx_line)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        tx_done <= 1'b1;
      else if (wr_valid) tx_done <= 1'b0;
      else if (load_go)  tx_done <= 1'b0;
      else if (char_end) tx_done <= 1'b1;
   end

   assign line_own = ctl_enable || busy || pend_brk || pend_idle;

endmodule

// File: rtl/utx_checker.sv
module utx_checker (
   input logic clk,
   input logic rst_n,
   input logic ctl_enable,
   input logic wr_valid,
   input logic baud_tick,
   input logic buf_empty,
   input logic tx_done,
   input logic tx_line,
   input logic line_own
);

   AST_FREE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      !line_own |-> tx_line);  // R10

   AST_WRITE_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |=> (!buf_empty && !tx_done));  // R4

   AST_HELD_WHILE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!buf_empty && !ctl_enable) |=> !buf_empty);  // R4

   AST_FROZEN_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      !baud_tick |=> $stable(tx_line));  // R11

   AST_DONE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      tx_done |-> tx_line);  // R5

endmodule

bind utx_core utx_checker u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ctl_enable (ctl_enable),
   .wr_valid   (wr_valid),
   .baud_tick  (baud_tick),
   .buf_empty  (buf_empty),
   .tx_done    (tx_done),
   .tx_line    (tx_line),
   .line_own   (line_own)
);

// File: tb/sim_utx_core.sv
module sim_utx_core;
   localparam int OVS  = 16;
   localparam int BASE = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ctl_enable = 1'b0, ctl_break = 1'b0, ctl_nine = 1'b0;
   logic wr_valid = 1'b0;
   logic [BASE:0] wr_data = '0;
   logic baud_tick = 1'b0;
   logic buf_empty, tx_done, tx_line, line_own;

   int n_checks = 0;
   int n_err = 0;
   int cycles = 0;
   int tick_div = 1;
   int tdiv_cnt = 0;
   bit tick_on = 1'b1;

   always #2 clk = ~clk;

   utx_core #(.OVS(OVS), .BASE_BITS(BASE)) u0 (
      .clk(clk), .rst_n(rst_n), .ctl_enable(ctl_enable), .ctl_break(ctl_break),
      .ctl_nine(ctl_nine), .wr_valid(wr_valid), .wr_data(wr_data),
      .baud_tick(baud_tick), .buf_empty(buf_empty), .tx_done(tx_done),
      .tx_line(tx_line), .line_own(line_own)
   );

   always @(negedge clk) begin
      if (!tick_on) begin
         baud_tick <= 1'b0;
      end else if (tdiv_cnt >= tick_div - 1) begin
         tdiv_cnt  <= 0;
         baud_tick <= 1'b1;
      end else begin
         tdiv_cnt  <= tdiv_cnt + 1;
         baud_tick <= 1'b0;
      end
   end

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles == 150000) begin
         n_checks++;
         n_err++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
         $finish;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic write_char(input logic [BASE:0] d);
      @(negedge clk);
      wr_data  = d;
      wr_valid = 1'b1;
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   task automatic pulse_break();
      @(negedge clk);
      ctl_break = 1'b1;
      @(negedge clk);
      ctl_break = 1'b0;
   endtask

   task automatic settle();
      int w = 0;
      repeat (4) @(negedge clk);
      while (!tx_done && w < 4000) begin
         @(negedge clk);
         w++;
      end
      repeat (2) @(negedge clk);
   endtask

   // waits for a start bit, samples each bit in its middle
   task automatic decode_char(input int exp, input bit nine, input string req);
      int bl = OVS * tick_div;
      int nb = nine ? 9 : 8;
      int w = 0;
      logic [8:0] got = '0;
      logic st, sp;
      while (tx_line !== 1'b0 && w < 4000) begin
         @(negedge clk);
         w++;
      end
      if (w >= 4000) begin
         check(1'b0, req, "no start bit", 1, 0);
         return;
      end
      repeat (bl / 2) @(negedge clk);
      st = tx_line;
      for (int i = 0; i < nb; i++) begin
         repeat (bl) @(negedge clk);
         got[i] = tx_line;
      end
      repeat (bl) @(negedge clk);
      sp = tx_line;
      check(st == 1'b0, req, "start bit", int'(st), 0);
      check(int'(got) == exp, req, "data", int'(got), exp);
      check(sp == 1'b1, req, "stop bit", int'(sp), 1);
   endtask

   task automatic measure_low(input int exp, input string req);
      int w = 0;
      int run = 0;
      while (tx_line !== 1'b0 && w < 4000) begin
         @(negedge clk);
         w++;
      end
      while (tx_line === 1'b0 && run < 4000) begin
         run++;
         @(negedge clk);
      end
      check(run == exp, req, "low run length", run, exp);
   endtask

   task automatic t_reset();
      check(tx_line == 1'b1, "R1", "line", int'(tx_line), 1);
      check(buf_empty == 1'b1, "R1", "buf_empty", int'(buf_empty), 1);
      check(tx_done == 1'b1, "R1", "tx_done", int'(tx_done), 1);
      check(line_own == 1'b0, "R1", "line_own", int'(line_own), 0);
   endtask

   task automatic t_data8();
      @(negedge clk);
      ctl_enable = 1'b1;
      settle();
      @(negedge clk);
      wr_data = 9'h0A5;
      wr_valid = 1'b1;
      @(negedge clk);
      wr_valid = 1'b0;
      // R4: flags cleared one cycle after the write
      check(buf_empty == 1'b0, "R4", "buf_empty after write", int'(buf_empty), 0);
      check(tx_done == 1'b0, "R4", "tx_done after write", int'(tx_done), 0);
      @(negedge clk);
      check(buf_empty == 1'b1, "R4", "buf_empty after load", int'(buf_empty), 1);
      decode_char(9'h0A5, 1'b0, "R2");
      repeat (OVS) @(negedge clk);
      check(tx_done == 1'b1, "R5", "tx_done after stop", int'(tx_done), 1);
      check(tx_line == 1'b1, "R5", "line idle", int'(tx_line), 1);
   endtask

   task automatic t_nine();
      @(negedge clk);
      ctl_nine = 1'b1;
      write_char(9'h1C3);
      decode_char(9'h1C3, 1'b1, "R3");
      settle();
      fork
         measure_low(11 * OVS, "R6 nine-bit break");
         pulse_break();
      join
      settle();
      @(negedge clk);
      ctl_nine = 1'b0;
   endtask

   task automatic t_priority();
      write_char(9'h055);
      decode_char(9'h055, 1'b0, "R9 first");
      // still in stop bit of the first character
      @(negedge clk);
      wr_data = 9'h0F0;
      wr_valid = 1'b1;
      @(negedge clk);
      wr_valid = 1'b0;
      ctl_break = 1'b1;
      @(negedge clk);
      ctl_break = 1'b0;
      decode_char(9'h0F0, 1'b0, "R9 data before break");
      measure_low(10 * OVS, "R9 break after data");
      settle();
   endtask

   task automatic t_held_break();
      fork
         measure_low(20 * OVS, "R7");
         begin
            @(negedge clk);
            ctl_break = 1'b1;
            repeat (60) @(negedge clk);
            ctl_break = 1'b0;
         end
      join
      settle();
   endtask

   task automatic t_idle();
      int n = 0;
      @(negedge clk);
      ctl_enable = 1'b0;
      @(negedge clk);
      ctl_enable = 1'b1;
      while (n < 1000) begin
         @(negedge clk);
         n++;
         if (n == 5) begin
            wr_data = 9'h03C;
            wr_valid = 1'b1;
         end else begin
            wr_valid = 1'b0;
         end
         if (tx_line === 1'b0) break;
      end
      check(n >= 161 && n <= 163, "R8", "cycles to next start", n, 162);
      decode_char(9'h03C, 1'b0, "R8");
      settle();
   endtask

   task automatic t_enable_off();
      write_char(9'h081);
      repeat (20) @(negedge clk);
      ctl_enable = 1'b0;
      @(negedge clk);
      check(line_own == 1'b1, "R10", "own right after disable", int'(line_own), 1);
      repeat (100) @(negedge clk);
      check(line_own == 1'b1, "R10", "own near frame end", int'(line_own), 1);
      repeat (100) @(negedge clk);
      check(line_own == 1'b0, "R10", "own after frame", int'(line_own), 0);
      check(tx_line == 1'b1, "R10", "line after release", int'(tx_line), 1);
   endtask

   task automatic t_disabled();
      write_char(9'h03C);
      repeat (40) @(negedge clk);
      check(buf_empty == 1'b0, "R4", "held while disabled", int'(buf_empty), 0);
      check(tx_line == 1'b1, "R4", "line while disabled", int'(tx_line), 1);
      fork
         measure_low(10 * OVS, "R6");
         begin
            pulse_break();
            repeat (30) @(negedge clk);
            check(line_own == 1'b1, "R10", "own during break", int'(line_own), 1);
         end
      join
      repeat (3) @(negedge clk);
      check(line_own == 1'b0, "R10", "own after break", int'(line_own), 0);
      check(buf_empty == 1'b0, "R9", "data kept behind break", int'(buf_empty), 0);
      @(negedge clk);
      ctl_enable = 1'b1;
      decode_char(9'h03C, 1'b0, "R9 data before idle");
      settle();
   endtask

   task automatic t_ticks();
      logic l0;
      @(negedge clk);
      tick_on = 1'b0;
      repeat (3) @(negedge clk);
      l0 = tx_line;
      write_char(9'h0C9);
      repeat (20) @(negedge clk);
      check(buf_empty == 1'b0, "R11", "no move without tick", int'(buf_empty), 0);
      check(tx_line == l0, "R11", "line frozen", int'(tx_line), int'(l0));
      tick_on = 1'b1;
      decode_char(9'h0C9, 1'b0, "R11");
      settle();
      @(negedge clk);
      tick_div = 2;
      fork
         measure_low(20 * OVS, "R11 half rate");
         pulse_break();
      join
      settle();
      tick_div = 1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_data8();
      t_nine();
      t_priority();
      t_held_break();
      t_idle();
      t_enable_off();
      t_disabled();
      t_ticks();
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end

endmodule